// File: doc/BRIEF.md
# Latched-Address Nonvolatile Byte Memory Controller

This block sits on the host side of a 512K x 8 nonvolatile byte memory that uses a pseudo-SRAM style interface. In that interface the address is captured when the chip becomes selected, and each access must be followed by a deselected recovery interval. A user agent issues single-byte reads and writes through a request/ready handshake. The controller turns each request into a timed select/strobe sequence on the memory pins and drives the bidirectional data bus only while a write is in progress. A read returns its byte with a one-cycle valid strobe.

Every minimum interval of the memory (enable width, write pulse, access time, precharge, bus float, address hold, full cycle) is a nanosecond parameter. Each is converted into a whole number of clock cycles by rounding up against the clock-period parameter, so the same RTL meets the memory's timing at any clock rate. Chip select is driven on the active-low enable; the active-high enable serves as the power-safe gate and is held low through reset.

The state machine has five states. ST_IDLE is standby with ready high. ST_SETUP presents the latched address with the chip still deselected. ST_READ and ST_WRITE are the selected phases. ST_PRECHG is the deselected recovery. The transitions are:
- ST_IDLE to ST_SETUP on an accepted request.
- ST_SETUP to ST_READ or ST_WRITE, according to the captured write flag.
- ST_READ or ST_WRITE to ST_PRECHG when the active-phase counter expires.
- ST_PRECHG to ST_IDLE when the recovery counter expires.

Top module: `psram_nv_ctrl`

## Requirements
- R1: While rst_n is low, mem_ce1_n is 1, mem_ce2 is 0, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and ready is 0.
- R2: A request is accepted on a rising clock edge where req and ready are both 1. Ready then stays 0 for exactly 1 + RD_ACT + RD_PRE cycles after a read, or 1 + WR_ACT + WR_PRE cycles after a write. A request still held at that point is accepted on the first cycle ready is 1 again.
- R3: mem_addr takes the request address at acceptance. It is already valid one cycle before the chip is selected and does not change while the chip is selected, whatever happens on req_addr.
- R4: A read selects the chip (mem_ce1_n 0) with mem_oe_n 0 and mem_we_n 1 for exactly RD_ACT = max(ceil(T_ENABLE/P), ceil(T_ACCESS/P)+1, ceil(T_AHOLD/P)) cycles. mem_we_n and mem_oe_n are never 0 together.
- R5: Read data is sampled from mem_dq_in at the clock edge that ends the last selected cycle of a read, one cycle after the access-time count ceil(T_ACCESS/P) has run out. It appears on rd_data together with a single-cycle rd_valid pulse in the next cycle. rd_valid never pulses for a write.
- R6: A write selects the chip with mem_we_n 0 and mem_oe_n 1 for exactly WR_ACT = max(ceil(T_ENABLE/P), ceil(T_WPULSE/P), ceil(T_AHOLD/P)) cycles. mem_dq_oe is 1 in exactly those cycles, with mem_dq_out holding the request's write byte.
- R7: After a read, mem_dq_oe stays 0 for at least ceil(T_FLOAT/P) cycles after deselection.
- R8: After every access the chip stays deselected for at least ceil(T_PRECHG/P) cycles. Two successive select edges are at least ceil(T_CYCLE/P) cycles apart.
- R9: mem_ce2 rises to 1 at the first clock edge after reset is released. While idle, the pins rest in standby: mem_ce1_n, mem_we_n and mem_oe_n at 1, mem_dq_oe at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, period CLK_PERIOD_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address of the request |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Controller can accept a request |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | One-cycle strobe, rd_data is valid |
| mem_addr | output | 19 | Memory address pins |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip enable, low in reset |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_in | input | 8 | Data received from the memory bus |

## Verification
A wrong state or a mis-loaded phase counter shows up on the memory pins within one access. A select phase that is a cycle short or long, a strobe on the wrong pin, or a driver enabled outside a write is caught at that access's deselect edge, well before the next request. A read captured one cycle early takes the memory model's filler byte instead of the stored byte, so rd_data is wrong in the very next cycle. A counter that miscounts recovery changes the ready-low span of that same request. A stale address or data register shows up as a mismatch on a later read of the affected location.

// File: rtl/psram_nv_pkg.sv
package psram_nv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_READ   = 3'd2,
        ST_WRITE  = 3'd3,
        ST_PRECHG = 3'd4
    } nv_state_e;

    // Minimum time in ns to whole clock cycles, rounded up.
    function automatic int ns_to_cyc(input int t_ns, input int per_ns);
        return (t_ns + per_ns - 1) / per_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_nv_tmr.sv
// Phase down-counter: loaded with (cycles - 1), reports done at zero.
module psram_nv_tmr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/psram_nv_fsm.sv
// Access sequencer: standby, setup, read/write select phase, precharge.
module psram_nv_fsm
    import psram_nv_pkg::*;
#(
    parameter int CNT_W  = 3,
    parameter int RD_ACT = 7,
    parameter int WR_ACT = 6,
    parameter int RD_PRE = 1,
    parameter int WR_PRE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_wr,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             cap,
    output logic             ready,
    output logic             ce1_n,
    output logic             ce2,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe
);

    localparam logic [CNT_W-1:0] RD_ACT_M1 = CNT_W'(RD_ACT - 1);
    localparam logic [CNT_W-1:0] WR_ACT_M1 = CNT_W'(WR_ACT - 1);
    localparam logic [CNT_W-1:0] RD_PRE_M1 = CNT_W'(RD_PRE - 1);
    localparam logic [CNT_W-1:0] WR_PRE_M1 = CNT_W'(WR_PRE - 1);

    nv_state_e state_q, state_d;
    logic      wr_q;
    logic      ce2_en_q;

    // State register, captured operation and power-safe enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            wr_q     <= 1'b0;
            ce2_en_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            ce2_en_q <= 1'b1;
            if (accept) begin
                wr_q <= req_wr;
            end
        end
    end

    // Transitions and phase-counter loads.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        cap      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req && ce2_en_q) begin
                    accept  = 1'b1;
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                tmr_val  = wr_q ? WR_ACT_M1 : RD_ACT_M1;
                state_d  = wr_q ? ST_WRITE : ST_READ;
            end
            ST_READ: begin
                if (tmr_done) begin
                    cap      = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = RD_PRE_M1;
                    state_d  = ST_PRECHG;
                end
            end
            ST_WRITE: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = WR_PRE_M1;
                    state_d  = ST_PRECHG;
                end
            end
            ST_PRECHG: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Pin levels decoded from the current state.
    always_comb begin
        ready = (state_q == ST_IDLE) && ce2_en_q;
        ce2   = ce2_en_q;
        ce1_n = 1'b1;
        we_n  = 1'b1;
        oe_n  = 1'b1;
        dq_oe = 1'b0;
        unique case (state_q)
            ST_READ: begin
                ce1_n = 1'b0;
                oe_n  = 1'b0;
            end
            ST_WRITE: begin
                ce1_n = 1'b0;
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_IDLE, ST_SETUP, ST_PRECHG: begin
                ce1_n = 1'b1;
            end
            default: ce1_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/psram_nv_dpath.sv
// Address/write-data hold registers and read capture.
module psram_nv_dpath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              cap,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdat_q;
    logic [DATA_W-1:0] rdat_q;
    logic              rvld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            wdat_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            wdat_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdat_q <= '0;
            rvld_q <= 1'b0;
        end else begin
            rvld_q <= cap;
            if (cap) begin
                rdat_q <= dq_in;
            end
        end
    end

    assign mem_addr = addr_q;
    assign dq_out   = wdat_q;
    assign rd_data  = rdat_q;
    assign rd_valid = rvld_q;

endmodule

// File: rtl/psram_nv_ctrl.sv
module psram_nv_ctrl
    import psram_nv_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_CYCLE_NS    = 150,
    parameter int T_ENABLE_NS   = 120,
    parameter int T_WPULSE_NS   = 120,
    parameter int T_ACCESS_NS   = 120,
    parameter int T_PRECHG_NS   = 20,
    parameter int T_FLOAT_NS    = 20,
    parameter int T_AHOLD_NS    = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int ENA_CYC  = ns_to_cyc(T_ENABLE_NS, CLK_PERIOD_NS);
    localparam int WP_CYC   = ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS);
    localparam int ACC_CYC  = ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS);
    localparam int PRE_CYC  = imax(1, ns_to_cyc(T_PRECHG_NS, CLK_PERIOD_NS));
    localparam int FLT_CYC  = ns_to_cyc(T_FLOAT_NS, CLK_PERIOD_NS);
    localparam int HOLD_CYC = ns_to_cyc(T_AHOLD_NS, CLK_PERIOD_NS);
    localparam int CYC_CYC  = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);

    // Selected-phase lengths; the read adds one cycle after access time.
    localparam int RD_ACT = imax(imax(ENA_CYC, ACC_CYC + 1), HOLD_CYC);
    localparam int WR_ACT = imax(imax(ENA_CYC, WP_CYC), HOLD_CYC);
    // Recovery: precharge, bus float after reads, and the cycle minimum
    // (one setup cycle is also spent deselected).
    localparam int RD_PRE = imax(imax(PRE_CYC, FLT_CYC), CYC_CYC - RD_ACT - 1);
    localparam int WR_PRE = imax(PRE_CYC, CYC_CYC - WR_ACT - 1);
    localparam int MAX_PH = imax(imax(RD_ACT, WR_ACT), imax(RD_PRE, WR_PRE));
    localparam int CNT_W  = imax(1, $clog2(MAX_PH + 1));

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             accept;
    logic             cap;

    psram_nv_tmr #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    psram_nv_fsm #(
        .CNT_W  (CNT_W),
        .RD_ACT (RD_ACT),
        .WR_ACT (WR_ACT),
        .RD_PRE (RD_PRE),
        .WR_PRE (WR_PRE)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_wr   (req_wr),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .accept   (accept),
        .cap      (cap),
        .ready    (ready),
        .ce1_n    (mem_ce1_n),
        .ce2      (mem_ce2),
        .we_n     (mem_we_n),
        .oe_n     (mem_oe_n),
        .dq_oe    (mem_dq_oe)
    );

    psram_nv_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cap       (cap),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (mem_dq_in),
        .mem_addr  (mem_addr),
        .dq_out    (mem_dq_out),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/psram_nv_ctrl_chk.sv
module psram_nv_ctrl_chk #(
    parameter int ADDR_W        = 19,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_ENABLE_NS   = 120
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);

    localparam int ENA_MIN = (T_ENABLE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

    logic [15:0] sel_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_cnt <= '0;
        end else if (!mem_ce1_n) begin
            sel_cnt <= sel_cnt + 16'd1;
        end else begin
            sel_cnt <= '0;
        end
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);

    p_rdy_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_ce1_n && !mem_dq_oe));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    p_enable_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce1_n) |-> (sel_cnt >= 16'(ENA_MIN)));

    p_vld_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_vld_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (mem_ce1_n && $past(!mem_oe_n)));

    p_drive_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_ce1_n && !mem_we_n && mem_oe_n));

    p_prechg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce1_n) |=> mem_ce1_n);

    p_ce2_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> mem_ce2);

endmodule

bind psram_nv_ctrl psram_nv_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_ENABLE_NS   (T_ENABLE_NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .ready     (ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/psram_nv_ctrl_tb_top.sv
module psram_nv_ctrl_tb_top;

    localparam int P   = 20;
    localparam int AW  = 19;
    localparam int DW  = 8;

    function automatic int cdiv(input int t);
        return (t + P - 1) / P;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected cycle counts from the requirements (R2, R4, R6, R7, R8).
    localparam int ENA = cdiv(120);
    localparam int WPC = cdiv(120);
    localparam int ACC = cdiv(120);
    localparam int PRE = cdiv(20);
    localparam int FLT = cdiv(20);
    localparam int HLD = cdiv(50);
    localparam int CYC = cdiv(150);
    localparam int RD_ACT = mx(mx(ENA, ACC + 1), HLD);
    localparam int WR_ACT = mx(mx(ENA, WPC), HLD);
    localparam int RD_PRE = mx(mx(PRE, FLT), CYC - RD_ACT - 1);
    localparam int WR_PRE = mx(PRE, CYC - WR_ACT - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ready;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [AW-1:0] mem_addr;
    logic          mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'hA5;

    always #10 clk = ~clk;

    psram_nv_ctrl #(.CLK_PERIOD_NS(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int last_wait = 0;
    logic [DW-1:0] exp_mem [int];
    logic [DW-1:0] mdl [int];

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {5'd0, a[18:16]};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Memory model and pin-protocol monitor, evaluated at falling edges.
    bit            prev_sel = 1'b0;
    bit            seen_sel = 1'b0;
    bit            wr_cyc   = 1'b0;
    int            act = 0;
    int            gap = 0;
    int            since_sel = 0;
    logic [AW-1:0] la = '0;
    logic [DW-1:0] wdat = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit sel = !mem_ce1_n && mem_ce2;
            if (mem_dq_oe) chk(sel && !mem_we_n, "R6 driver outside write", 1, 0);
            if (!mem_we_n) chk(mem_oe_n, "R4 strobes together", 0, 1);
            if (sel) begin
                if (!prev_sel) begin
                    if (seen_sel) begin
                        chk(gap >= PRE, "R8 precharge", gap, PRE);
                        chk(since_sel >= CYC, "R8 cycle time", since_sel, CYC);
                        if (!mem_we_n) chk(gap >= FLT, "R7 float", gap, FLT);
                    end
                    seen_sel  = 1'b1;
                    since_sel = 0;
                    la        = mem_addr;
                    act       = 0;
                    wr_cyc    = !mem_we_n;
                end
                act++;
                chk(mem_addr == la, "R3 address stable", int'(mem_addr), int'(la));
                if (wr_cyc) begin
                    chk(!mem_we_n && mem_dq_oe, "R6 write strobe", 0, 1);
                    wdat = mem_dq_out;
                end else begin
                    chk(!mem_oe_n && mem_we_n, "R4 read strobe", int'(mem_oe_n), 0);
                end
            end else if (prev_sel) begin
                chk(act == (wr_cyc ? WR_ACT : RD_ACT), wr_cyc ? "R6 write width" : "R4 read width",
                    act, wr_cyc ? WR_ACT : RD_ACT);
                if (wr_cyc) mdl[int'(la)] = wdat;
                gap = 0;
            end
            if (!sel) gap++;
            since_sel++;
            prev_sel = sel;
            if (sel && !wr_cyc && act > ACC)
                mem_dq_in = mdl.exists(int'(la)) ? mdl[int'(la)] : init_val(la);
            else
                mem_dq_in = 8'hA5;
        end
    end

    task automatic do_op(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d, input bit keep);
        int waitc;
        int lat;
        int exp_lat;
        logic [DW-1:0] expv;
        req_addr  = a;
        req_wr    = wr;
        req_wdata = d;
        req       = 1'b1;
        waitc = 0;
        while (!ready) begin
            @(negedge clk);
            waitc++;
        end
        last_wait = waitc;
        expv = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_val(a);
        if (wr) exp_mem[int'(a)] = d;
        @(negedge clk);
        if (!keep) req = 1'b0;
        lat = 0;
        while (!ready) begin
            lat++;
            if (!wr && lat == RD_ACT + 2)
                chk(rd_valid && rd_data == expv, "R5 read data", rd_valid ? int'(rd_data) : -1, int'(expv));
            else if (rd_valid)
                chk(1'b0, "R5 stray valid", lat, RD_ACT + 2);
            if (!keep) begin
                req_addr  = AW'($urandom);
                req_wdata = DW'($urandom);
            end
            @(negedge clk);
        end
        exp_lat = wr ? (1 + WR_ACT + WR_PRE) : (1 + RD_ACT + RD_PRE);
        chk(lat == exp_lat, "R2 busy span", lat, exp_lat);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] pool [8];
        bit prev_keep;
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) pool[i] = AW'($urandom);
        pool[0] = '0;
        pool[1] = '1;

        repeat (3) @(negedge clk);
        // R1: reset levels
        chk(mem_ce1_n == 1'b1, "R1 ce1_n", int'(mem_ce1_n), 1);
        chk(mem_ce2 == 1'b0, "R1 ce2", int'(mem_ce2), 0);
        chk(mem_we_n && mem_oe_n, "R1 strobes", int'({mem_we_n, mem_oe_n}), 3);
        chk(!mem_dq_oe, "R1 dq_oe", int'(mem_dq_oe), 0);
        chk(!ready, "R1 ready", int'(ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce2 == 1'b1, "R9 ce2 after reset", int'(mem_ce2), 1);
        chk(ready == 1'b1, "R2 ready in idle", int'(ready), 1);
        chk(mem_ce1_n && !mem_dq_oe, "R9 standby", int'(mem_ce1_n), 1);

        // Directed corners
        do_op('0, 1'b0, 8'h00, 1'b0);            // unwritten location
        do_op('1, 1'b1, 8'h3C, 1'b0);            // top address write
        do_op('1, 1'b0, 8'h00, 1'b0);
        do_op('0, 1'b1, 8'hFF, 1'b1);            // held request, back to back
        do_op('0, 1'b0, 8'h00, 1'b1);
        chk(last_wait == 0, "R2 held request taken at once", last_wait, 0);
        do_op(19'h12345, 1'b1, 8'h11, 1'b1);
        chk(last_wait == 0, "R2 held request taken at once", last_wait, 0);
        do_op(19'h12345, 1'b1, 8'h22, 1'b0);
        do_op(19'h12345, 1'b0, 8'h00, 1'b0);

        // Random mix
        prev_keep = 1'b0;
        for (int n = 0; n < 300; n++) begin
            logic [AW-1:0] a;
            bit keep;
            a = AW'($urandom);
            if ($urandom_range(0, 3) != 0) a = pool[$urandom_range(0, 7)];
            keep = ($urandom_range(0, 3) == 0);
            if (!prev_keep && $urandom_range(0, 2) == 0)
                repeat ($urandom_range(1, 3)) @(negedge clk);
            do_op(a, $urandom_range(0, 1) == 1, DW'($urandom), keep);
            prev_keep = keep;
        end
        req = 1'b0;
        repeat (12) @(negedge clk);
        chk(mem_ce1_n && mem_we_n && mem_oe_n && !mem_dq_oe && ready, "R9 idle standby",
            int'({mem_ce1_n, mem_we_n, mem_oe_n, mem_dq_oe, ready}), 5'b11101);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule